// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block brings a serial link up in two steps. When started, it rewrites the
maximum-speed field of the link controller so that the controller may only train
at first-generation speed. It then enables the training state machine and waits
for the link to come up. If the second-generation speed was requested, it then
raises the speed field to 2 and sets the directed-speed-change bit. Next it polls
that bit until it self-clears, or skips the poll when configured to do so. It
then checks that the link is up again. Finally it reads the negotiated speed
from the link status word and reports it with a one-cycle done pulse.

Every register access goes over a plain register-file port. Reads return data in
the same cycle. Each field update is a read followed by a write of the modified
word, so the other bits of the word are kept. If any wait times out, the block
takes a receiver-reset path. It sets two override bits, holds them, clears them
again, and then gives a one-cycle error pulse. All waits are counted in clock
cycles and set by parameters.

Top module: `link_speed_seq`

## Requirements
- R1: On start, the speed field (bits 3:0 of register 0) is rewritten to 1 with bits 31:4 kept, and this happens before the training enable `ltssm_en_o` rises.
- R2: If `link_up_i` does not rise within LINK_TMO+1 cycles after training is enabled, the block takes the error path.
- R3: With `cfg_gen2_i` set, after the first link-up the speed field of register 0 is rewritten to 2. After that, bit 17 of register 1 is set with a single write.
- R4: Without the skip flag, register 1 is read until bit 17 reads 0, with at most POLL_RETRIES reads. If all POLL_RETRIES reads see the bit still set, the block takes the error path.
- R5: With `cfg_skip_clr_i` set, register 1 is not polled after the speed-change write, and the block goes straight to the second link check.
- R6: After the speed change, `link_up_i` must be high again within LINK_TMO+1 cycles, or the block takes the error path.
- R7: On success, `speed_o` holds bits 19:16 of register 2, read after the last link check.
- R8: The error path sets bits 5 and 3 of register 3, keeping its other bits. These bits stay set for exactly HOLD_CYC+3 cycles and are then cleared, leaving the register as it was before.
- R9: `done_o` and `err_o` are single-cycle pulses, never high together, and exactly one of them ends each run.
- R10: `speed_o` keeps its value after a run until the next accepted start, which clears it to 0. It stays 0 after an error.
- R11: With `cfg_gen2_i` clear, the block ends right after the first link-up, with no write to register 1, and reports speed 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a bring-up run when idle |
| cfg_gen2_i | input | 1 | Target second-generation speed (sampled at start) |
| cfg_skip_clr_i | input | 1 | Skip the wait for the speed-change bit to clear (sampled at start) |
| link_up_i | input | 1 | Link-up indication from the training logic |
| ltssm_en_o | output | 1 | Training state machine enable |
| rf_rd_en_o | output | 1 | Register-file read strobe |
| rf_wr_en_o | output | 1 | Register-file write strobe |
| rf_addr_o | output | 2 | Register index |
| rf_wdata_o | output | 32 | Write data |
| rf_rdata_i | input | 32 | Read data, valid in the same cycle as the read strobe |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| speed_o | output | 4 | Reported negotiated speed |

## Verification
`done_o` and `speed_o` update together, one cycle after the status read. `err_o` rises one cycle after the write that clears the override bits. The bench samples on falling edges. It waits for either pulse, checks the outcome and speed on that same falling edge, and checks that the pulse has dropped on the next one. Register traffic is counted by a falling-edge monitor on the strobes. The override hold is measured in falling edges of the model register, where the expected count of HOLD_CYC+3 follows from the hold state, the re-read and the clearing write.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int REG_DW = 32;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] RA_CAP  = 2'd0;
  localparam logic [REG_AW-1:0] RA_CTRL = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd2;
  localparam logic [REG_AW-1:0] RA_OVRD = 2'd3;

  localparam int DSC_BIT = 17;

  typedef enum logic [4:0] {
    S_IDLE, S_CAP_RD, S_CAP_WR, S_LINK1,
    S_UP2_RD, S_UP2_WR, S_DSC_RD, S_DSC_WR,
    S_POLL_RD, S_POLL_GAP, S_LINK2, S_STAT_RD,
    S_ERR_RD, S_ERR_SET, S_ERR_HOLD, S_ERR_RD2, S_ERR_CLR
  } lsb_state_e;

  function automatic logic [REG_DW-1:0] with_max_speed(input logic [REG_DW-1:0] v,
                                                        input logic [3:0] gen);
    return {v[REG_DW-1:4], gen};
  endfunction

  function automatic logic [3:0] speed_field(input logic [REG_DW-1:0] s);
    return s[19:16];
  endfunction

  function automatic logic [REG_DW-1:0] rx_override(input logic [REG_DW-1:0] v,
                                                     input logic on);
    logic [REG_DW-1:0] m;
    m = (REG_DW'(1) << 5) | (REG_DW'(1) << 3);
    return on ? (v | m) : (v & ~m);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lsb_countdown.sv
module lsb_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
  import lsb_pkg::*;
#(
  parameter int LINK_TMO     = 1000,
  parameter int POLL_GAP     = 16,
  parameter int POLL_RETRIES = 200,
  parameter int HOLD_CYC     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cfg_gen2_i,
  input  logic              cfg_skip_clr_i,
  input  logic              link_up_i,
  output logic              ltssm_en_o,
  output logic              rf_rd_en_o,
  output logic              rf_wr_en_o,
  output logic [REG_AW-1:0] rf_addr_o,
  output logic [REG_DW-1:0] rf_wdata_o,
  input  logic [REG_DW-1:0] rf_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [3:0]        speed_o
);
  localparam int WT_MAX = max3(LINK_TMO, POLL_GAP, HOLD_CYC);
  localparam int TW     = $clog2(WT_MAX + 1);
  localparam int RW     = $clog2(POLL_RETRIES + 1);

  lsb_state_e        st_q, st_nxt;
  logic [REG_DW-1:0] shadow_q;
  logic              gen2_q, skip_q, ltssm_q, done_q, err_q;
  logic [3:0]        speed_q;

  logic              wt_load, wt_zero, rc_load, rc_dec, rc_zero;
  logic [TW-1:0]     wt_val;

  // named events for the checks below
  wire ev_start   = (st_q == S_IDLE) && start_i;
  wire ev_cap_wr  = rf_wr_en_o && (rf_addr_o == RA_CAP);
  wire ev_ctrl_wr = rf_wr_en_o && (rf_addr_o == RA_CTRL);
  wire ev_ovrd_wr = rf_wr_en_o && (rf_addr_o == RA_OVRD);
  wire dsc_busy   = rf_rdata_i[DSC_BIT];

  always_comb begin
    st_nxt     = st_q;
    rf_rd_en_o = 1'b0;
    rf_wr_en_o = 1'b0;
    rf_addr_o  = RA_CAP;
    rf_wdata_o = shadow_q;
    unique case (st_q)
      S_IDLE:     if (start_i) st_nxt = S_CAP_RD;
      S_CAP_RD:   begin rf_rd_en_o = 1'b1; st_nxt = S_CAP_WR; end
      S_CAP_WR:   begin
        rf_wr_en_o = 1'b1; rf_wdata_o = with_max_speed(shadow_q, 4'd1); st_nxt = S_LINK1;
      end
      S_LINK1:    if (link_up_i) st_nxt = gen2_q ? S_UP2_RD : S_STAT_RD;
                  else if (wt_zero) st_nxt = S_ERR_RD;
      S_UP2_RD:   begin rf_rd_en_o = 1'b1; st_nxt = S_UP2_WR; end
      S_UP2_WR:   begin
        rf_wr_en_o = 1'b1; rf_wdata_o = with_max_speed(shadow_q, 4'd2); st_nxt = S_DSC_RD;
      end
      S_DSC_RD:   begin rf_rd_en_o = 1'b1; rf_addr_o = RA_CTRL; st_nxt = S_DSC_WR; end
      S_DSC_WR:   begin
        rf_wr_en_o = 1'b1; rf_addr_o = RA_CTRL;
        rf_wdata_o = shadow_q | (REG_DW'(1) << DSC_BIT);
        st_nxt = skip_q ? S_LINK2 : S_POLL_RD;
      end
      S_POLL_RD:  begin
        rf_rd_en_o = 1'b1; rf_addr_o = RA_CTRL;
        if (!dsc_busy)    st_nxt = S_LINK2;
        else if (rc_zero) st_nxt = S_ERR_RD;
        else              st_nxt = S_POLL_GAP;
      end
      S_POLL_GAP: if (wt_zero) st_nxt = S_POLL_RD;
      S_LINK2:    if (link_up_i) st_nxt = S_STAT_RD;
                  else if (wt_zero) st_nxt = S_ERR_RD;
      S_STAT_RD:  begin rf_rd_en_o = 1'b1; rf_addr_o = RA_STAT; st_nxt = S_IDLE; end
      S_ERR_RD:   begin rf_rd_en_o = 1'b1; rf_addr_o = RA_OVRD; st_nxt = S_ERR_SET; end
      S_ERR_SET:  begin
        rf_wr_en_o = 1'b1; rf_addr_o = RA_OVRD; rf_wdata_o = rx_override(shadow_q, 1'b1);
        st_nxt = S_ERR_HOLD;
      end
      S_ERR_HOLD: if (wt_zero) st_nxt = S_ERR_RD2;
      S_ERR_RD2:  begin rf_rd_en_o = 1'b1; rf_addr_o = RA_OVRD; st_nxt = S_ERR_CLR; end
      S_ERR_CLR:  begin
        rf_wr_en_o = 1'b1; rf_addr_o = RA_OVRD; rf_wdata_o = rx_override(shadow_q, 1'b0);
        st_nxt = S_IDLE;
      end
      default:    st_nxt = S_IDLE;
    endcase
  end

  // wait timer: reloaded on every state change, value picked by the next state
  always_comb begin
    wt_load = (st_nxt != st_q);
    if (st_nxt == S_LINK1 || st_nxt == S_LINK2) wt_val = TW'(LINK_TMO);
    else if (st_nxt == S_POLL_GAP)              wt_val = TW'(POLL_GAP);
    else                                        wt_val = TW'(HOLD_CYC);
  end

  lsb_countdown #(.W(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wt_load), .load_val(wt_val),
    .dec(1'b1), .zero_o(wt_zero)
  );

  // retry counter: armed by the speed-change write, spent by each busy poll
  assign rc_load = (st_q == S_DSC_WR);
  assign rc_dec  = (st_q == S_POLL_RD) && dsc_busy;

  lsb_countdown #(.W(RW)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(rc_load), .load_val(RW'(POLL_RETRIES - 1)),
    .dec(rc_dec), .zero_o(rc_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      shadow_q <= '0;
      gen2_q   <= 1'b0;
      skip_q   <= 1'b0;
      ltssm_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      speed_q  <= '0;
    end else begin
      st_q   <= st_nxt;
      done_q <= (st_q == S_STAT_RD);
      err_q  <= (st_q == S_ERR_CLR);
      if (rf_rd_en_o) shadow_q <= rf_rdata_i;
      if (ev_start) begin
        gen2_q  <= cfg_gen2_i;
        skip_q  <= cfg_skip_clr_i;
        ltssm_q <= 1'b0;
        speed_q <= '0;
      end
      if (st_q == S_CAP_WR)  ltssm_q <= 1'b1;
      if (st_q == S_STAT_RD) speed_q <= speed_field(rf_rdata_i);
    end
  end

  assign ltssm_en_o = ltssm_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign speed_o    = speed_q;

  // training is only enabled right after the speed field was forced to 1
  p_gen1_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en_o) |-> $past(ev_cap_wr && rf_wdata_o[3:0] == 4'd1));

  // speed-change register is touched only on a second-generation run
  p_dsc_gen2_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_wr |-> gen2_q);

  // the error pulse follows the write that drops both override bits
  p_ovrd_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(ev_ovrd_wr && !rf_wdata_o[5] && !rf_wdata_o[3]));

  p_excl_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_speed_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speed_o) |-> (done_o || $past(ev_start)));
endmodule

// File: tb/link_speed_seq_tb.sv
module link_speed_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO    = 40;
  localparam int GAP    = 3;
  localparam int RETRY  = 200;
  localparam int HOLD   = 20;
  localparam int NROWS  = 8;
  localparam logic [31:0] CAP_INIT  = 32'h5A5A_0003;
  localparam logic [31:0] OVRD_INIT = 32'h0000_0C44;

  // {gen2, skip, partner[1:0], link1_ok, link2_ok, self_clear, exp_err, exp_speed[3:0]}
  localparam logic [11:0] VEC [NROWS] = '{
    12'h2E1, 12'hAE2, 12'h9E1, 12'hEC2, 12'hA70, 12'hAB0, 12'hAD0, 12'hDC1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, gen2 = 1'b0, skip = 1'b0, link_up;
  logic ltssm_en, rf_rd, rf_wr, done, err;
  logic [1:0]  rf_addr;
  logic [31:0] rf_wdata, rf_rdata;
  logic [3:0]  speed;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_speed_seq #(.LINK_TMO(TMO), .POLL_GAP(GAP), .POLL_RETRIES(RETRY), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_gen2_i(gen2), .cfg_skip_clr_i(skip),
    .link_up_i(link_up), .ltssm_en_o(ltssm_en), .rf_rd_en_o(rf_rd), .rf_wr_en_o(rf_wr),
    .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata),
    .done_o(done), .err_o(err), .speed_o(speed)
  );

  // register file and link-partner model
  logic [31:0] regs [4];
  logic [1:0]  m_partner = 2'd2;
  logic        m_l1ok = 1'b1, m_l2ok = 1'b1, m_clr = 1'b1;
  logic        l1_done, sc_act;
  int          lcnt, sc_cnt;

  assign rf_rdata = regs[rf_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      regs[0] <= CAP_INIT; regs[1] <= 32'h0000_1234;
      regs[2] <= 32'h0;    regs[3] <= OVRD_INIT;
      link_up <= 1'b0; l1_done <= 1'b0; sc_act <= 1'b0; lcnt <= 0; sc_cnt <= 0;
    end else begin
      if (rf_wr) regs[rf_addr] <= rf_wdata;
      if (!ltssm_en) begin
        link_up <= 1'b0; l1_done <= 1'b0; sc_act <= 1'b0; lcnt <= 0;
      end else if (sc_act) begin
        sc_cnt <= sc_cnt + 1;
        if (sc_cnt == 5) begin
          sc_act <= 1'b0;
          link_up <= m_l2ok;
          regs[2][19:16] <= (regs[0][3:0] < {2'b0, m_partner}) ? regs[0][3:0] : {2'b0, m_partner};
          if (m_clr) regs[1][17] <= 1'b0;
        end
      end else if (!l1_done && m_l1ok) begin
        lcnt <= lcnt + 1;
        if (lcnt == 9) begin link_up <= 1'b1; l1_done <= 1'b1; regs[2][19:16] <= 4'd1; end
      end
      if (rf_wr && rf_addr == 2'd1 && rf_wdata[17]) begin
        sc_act <= 1'b1; sc_cnt <= 0; link_up <= 1'b0;
      end
    end
  end

  // traffic monitor
  int ctrl_rd, ctrl_wr, hold_cnt, done_cnt, err_cnt, both_cnt;
  logic [31:0] cap_at_en, ovrd_seen;
  logic ltssm_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      ctrl_rd = 0; ctrl_wr = 0; hold_cnt = 0; done_cnt = 0; err_cnt = 0; both_cnt = 0;
      cap_at_en = 32'h0; ovrd_seen = 32'h0; ltssm_prev = 1'b0;
    end else begin
      if (rf_rd && rf_addr == 2'd1) ctrl_rd++;
      if (rf_wr && rf_addr == 2'd1) ctrl_wr++;
      if (regs[3][5]) begin hold_cnt++; ovrd_seen = regs[3]; end
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (done && err) both_cnt++;
      if (ltssm_en && !ltssm_prev) cap_at_en = regs[0];
      ltssm_prev = ltssm_en;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_outcome(output bit got);
    got = 1'b0;
    for (int n = 0; n < 5000; n++) begin
      if (done || err) begin got = 1'b1; break; end
      @(negedge clk);
    end
    if (!got) check(1'b0, "R9 watchdog outcome", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    do_reset();
    // reset state
    check(!done && !err && !ltssm_en && speed == 4'd0 && !rf_rd && !rf_wr,
          "R9 reset outputs idle", {done, err, ltssm_en, rf_rd, rf_wr, speed}, 0);

    for (int r = 0; r < NROWS; r++) begin
      logic [11:0] v;
      v = VEC[r];
      do_reset();
      gen2 = v[11]; skip = v[10];
      m_partner = v[9:8]; m_l1ok = v[7]; m_l2ok = v[6]; m_clr = v[5];
      pulse_start();
      wait_outcome(got);
      if (!got) break;
      check(err == v[4] && done == !v[4], "R9 outcome R2 R6 R4", {done, err}, {!v[4], v[4]});
      check(speed == v[3:0], "R7 reported speed", speed, v[3:0]);
      @(negedge clk);
      check(!done && !err && done_cnt + err_cnt == 1 && both_cnt == 0, "R9 single pulse",
            done_cnt + err_cnt, 1);
      check(cap_at_en == 32'h5A5A_0001, "R1 speed field forced to 1", cap_at_en, 32'h5A5A_0001);
      if (v[4]) begin
        check(hold_cnt == HOLD + 3, "R8 override hold length", hold_cnt, HOLD + 3);
        check(ovrd_seen == (OVRD_INIT | 32'h28), "R8 override bits set", ovrd_seen, OVRD_INIT | 32'h28);
        check(regs[3] == OVRD_INIT, "R8 override restored", regs[3], OVRD_INIT);
        check(speed == 4'd0, "R10 speed zero after error", speed, 0);
      end else begin
        check(hold_cnt == 0, "R8 no override on success", hold_cnt, 0);
      end
      if (!v[11]) check(ctrl_wr == 0, "R11 gen1 run leaves speed-change alone", ctrl_wr, 0);
      if (v[11] && v[7]) begin
        check(ctrl_wr == 1, "R3 one speed-change write", ctrl_wr, 1);
        check(regs[0] == 32'h5A5A_0002, "R3 speed field raised to 2", regs[0], 32'h5A5A_0002);
        if (v[10]) check(ctrl_rd == 1, "R5 no poll when skipping", ctrl_rd, 1);
        else if (!v[5]) check(ctrl_rd == 1 + RETRY, "R4 poll count on timeout", ctrl_rd, 1 + RETRY);
        else check(ctrl_rd >= 2, "R4 polled until clear", ctrl_rd, 2);
      end
    end

    // R10: hold after success, clear on next start
    do_reset();
    gen2 = 1'b1; skip = 1'b0; m_partner = 2'd2; m_l1ok = 1'b1; m_l2ok = 1'b1; m_clr = 1'b1;
    pulse_start();
    wait_outcome(got);
    repeat (20) @(negedge clk);
    check(speed == 4'd2, "R10 speed held while idle", speed, 2);
    start = 1'b1; gen2 = 1'b0; @(negedge clk); start = 1'b0;
    check(speed == 4'd0, "R10 speed cleared on start", speed, 0);
    wait_outcome(got);
    check(done && speed == 4'd1, "R11 gen1 rerun reports 1", speed, 1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule